// File: doc/BRIEF.md
# Two-Phase Pipeline Sequencer with Shared Memory Port

This block paces a four-stage in-order processor pipeline so that one single-port memory can hold both instructions and data. The stages are fetch, decode, execute and a combined memory-access/writeback stage. A phase bit flips on every clock that is not stalled. In the even phase the fetch and execute stages are enabled. In the odd phase the decode and memory/writeback stages are enabled. An instruction fetch and a load or store therefore never need the memory in the same cycle, so the block needs no arbiter and no conflict stall.

The single memory port is shared by phase. In the even phase it carries the program counter, with all write strobes held low. In the odd phase it carries the load/store request: address, write data and byte strobes. The memory answers one cycle after it sees an address. The block captures that answer into an instruction register after a fetch and into a load-data register after a load.

A synchronous stall input freezes the sequence. While stall is high, every stage enable and every strobe is low and the phase bit holds its value. Decode, the ALU, the register file and program loading belong to other blocks.

Top module: `twophase_seq`

## Requirements
- R1: While reset (`rst_ni` low) is asserted and in the first cycle after it, the phase is even (`phase_o`=0). The instruction and load-data registers read zero, and `mem_strb_o` is zero.
- R2: On every rising clock edge where `stall_i` is low, `phase_o` inverts.
- R3: In an unstalled even cycle, `en_fetch_o` and `en_exec_o` are 1, and `en_decode_o` and `en_memwb_o` are 0.
- R4: In an unstalled odd cycle, `en_decode_o` and `en_memwb_o` are 1, and `en_fetch_o` and `en_exec_o` are 0. `en_fetch_o` and `en_memwb_o` are never high in the same cycle.
- R5: `mem_addr_o` equals `pc_i` in the even phase and `ls_addr_i` in the odd phase.
- R6: `mem_strb_o` equals `ls_strb_i` and `mem_wdata_o` equals `ls_wdata_i` only in an unstalled odd cycle with `ls_valid_i`=1 and `ls_we_i`=1. In every other cycle both outputs are zero.
- R7: The read data returned in the cycle after an even-phase fetch is loaded into `instr_o`. It is visible from the second clock edge after the fetch cycle.
- R8: The read data returned in the cycle after an odd-phase load (`ls_valid_i`=1, `ls_we_i`=0) is loaded into `load_data_o`, visible from the second edge after the load cycle. A store or an idle odd cycle leaves `load_data_o` unchanged.
- R9: While `stall_i` is high, all four stage enables and `mem_strb_o` are zero, and `phase_o` keeps its value across the edge.
- R10: After `stall_i` falls, the sequence resumes in the phase where it stopped, with that phase's stage pair enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| stall_i | input | 1 | Freeze the phase and drop all enables |
| pc_i | input | ADDR_W | Fetch address (program counter) |
| ls_valid_i | input | 1 | A load/store request is present |
| ls_we_i | input | 1 | 1 = store, 0 = load |
| ls_addr_i | input | ADDR_W | Load/store address |
| ls_wdata_i | input | DATA_W | Store data |
| ls_strb_i | input | DATA_W/8 | Store byte strobes |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after the address |
| phase_o | output | 1 | Current phase: 0 even, 1 odd |
| en_fetch_o | output | 1 | Fetch stage enable |
| en_decode_o | output | 1 | Decode stage enable |
| en_exec_o | output | 1 | Execute stage enable |
| en_memwb_o | output | 1 | Memory/writeback stage enable |
| mem_addr_o | output | ADDR_W | Shared memory address |
| mem_wdata_o | output | DATA_W | Shared memory write data |
| mem_strb_o | output | DATA_W/8 | Shared memory byte write strobes |
| instr_o | output | DATA_W | Captured instruction word |
| load_data_o | output | DATA_W | Captured load data |

## Verification
The enables, `mem_addr_o`, `mem_wdata_o` and `mem_strb_o` are combinational from the phase register and the inputs. The bench drives inputs at the falling edge and checks these outputs 1 ns later, in the same cycle. `phase_o` changes one edge after an unstalled cycle. The two capture registers reflect an access two edges after the cycle that issued it, because the bench memory registers its data one edge after the address and the capture adds a second edge. The capture checks therefore skip one full cycle after issue and sample at the second falling edge. Each task first waits for the phase it needs, so every expectation is tied to a known phase.

// File: rtl/tps_pkg.sv
// Shared types for the two-phase sequencer.
// Stage indices follow pipeline order. Bit 0 of a stage index selects the
// phase in which that stage is enabled.
package tps_pkg;

    localparam int NUM_STAGES = 4;

    typedef enum logic [1:0] {
        STG_FETCH  = 2'd0,
        STG_DECODE = 2'd1,
        STG_EXEC   = 2'd2,
        STG_MEMWB  = 2'd3
    } stage_e;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // Phase in which stage s is active: even-index stages run in the even phase.
    function automatic phase_e stage_phase(input int s);
        return ((s % 2) == 1) ? PH_ODD : PH_EVEN;
    endfunction

endpackage

// File: rtl/tps_phase_gen.sv
// Phase generator: a one-bit phase register plus one enable per stage.
// Assumes a synchronous active-low reset. Stall holds the phase and drops
// every enable in the same cycle.
module tps_phase_gen
    import tps_pkg::*;
#(
    parameter int NSTG = NUM_STAGES
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            stall_i,
    output phase_e          phase_o,
    output logic [NSTG-1:0] en_o
);

    phase_e phase_q;

    // Flip the phase on every unstalled edge; reset to even.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_EVEN;
        end else if (!stall_i) begin
            phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        end
    end

    // One enable per stage, active when its phase matches and no stall.
    for (genvar s = 0; s < NSTG; s++) begin : g_en
        assign en_o[s] = !stall_i && (phase_q == stage_phase(s));
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/tps_mem_route.sv
// Memory port router: chooses the source of the single memory port by phase.
// Even phase: fetch address, no write. Odd phase: load/store request, with
// write strobes only for an unstalled valid store. It also flags which
// capture register should take the data returned one cycle later.
module tps_mem_route
    import tps_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  phase_e            phase_i,
    input  logic              stall_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              ls_valid_i,
    input  logic              ls_we_i,
    input  logic [ADDR_W-1:0] ls_addr_i,
    input  logic [DATA_W-1:0] ls_wdata_i,
    input  logic [STRB_W-1:0] ls_strb_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [STRB_W-1:0] mem_strb_o,
    output logic              issue_fetch_o,
    output logic              issue_load_o
);

    logic odd_active;
    logic store_go;

    assign odd_active = (phase_i == PH_ODD) && !stall_i;
    assign store_go   = odd_active && ls_valid_i && ls_we_i;

    // Address mux: phase picks the owner of the port.
    always_comb begin
        if (phase_i == PH_ODD) begin
            mem_addr_o = ls_addr_i;
        end else begin
            mem_addr_o = pc_i;
        end
    end

    // Write path: driven only for a store in an active odd cycle.
    always_comb begin
        mem_wdata_o = '0;
        mem_strb_o  = '0;
        if (store_go) begin
            mem_wdata_o = ls_wdata_i;
            mem_strb_o  = ls_strb_i;
        end
    end

    // Read tagging for the capture stage.
    always_comb begin
        issue_fetch_o = (phase_i == PH_EVEN) && !stall_i;
        issue_load_o  = odd_active && ls_valid_i && !ls_we_i;
    end

endmodule

// File: rtl/tps_rd_capture.sv
// Read capture: the memory returns data one cycle after the address. For
// each read kind a pending flag remembers the issue, and the data is latched
// on the following edge. Entry 0 holds instructions, entry 1 load data.
module tps_rd_capture #(
    parameter int DATA_W = 32,
    parameter int NCAP   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCAP-1:0]   issue_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] cap_o [NCAP]
);

    for (genvar c = 0; c < NCAP; c++) begin : g_cap
        logic              pend_q;
        logic [DATA_W-1:0] data_q;

        // Remember that a read of this kind was issued last cycle.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= issue_i[c];
            end
        end

        // Latch returned data in the cycle after the issue.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                data_q <= '0;
            end else if (pend_q) begin
                data_q <= rdata_i;
            end
        end

        assign cap_o[c] = data_q;
    end

endmodule

// File: rtl/twophase_seq.sv
// Two-phase pipeline sequencer top. It connects the phase generator, the
// memory port router and the read capture. Assumes a synchronous memory with
// one cycle of read latency and a synchronous active-low reset.
module twophase_seq
    import tps_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STRB_W = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stall_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              ls_valid_i,
    input  logic              ls_we_i,
    input  logic [ADDR_W-1:0] ls_addr_i,
    input  logic [DATA_W-1:0] ls_wdata_i,
    input  logic [STRB_W-1:0] ls_strb_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              phase_o,
    output logic              en_fetch_o,
    output logic              en_decode_o,
    output logic              en_exec_o,
    output logic              en_memwb_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [STRB_W-1:0] mem_strb_o,
    output logic [DATA_W-1:0] instr_o,
    output logic [DATA_W-1:0] load_data_o
);

    localparam int CAP_INSTR = 0;
    localparam int CAP_LOAD  = 1;
    localparam int NCAP      = 2;

    phase_e                  phase;
    logic [NUM_STAGES-1:0]   en_vec;
    logic                    issue_fetch;
    logic                    issue_load;
    logic [NCAP-1:0]         issue_vec;
    logic [DATA_W-1:0]       cap [NCAP];

    tps_phase_gen #(
        .NSTG (NUM_STAGES)
    ) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stall_i (stall_i),
        .phase_o (phase),
        .en_o    (en_vec)
    );

    tps_mem_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STRB_W (STRB_W)
    ) u_route (
        .phase_i       (phase),
        .stall_i       (stall_i),
        .pc_i          (pc_i),
        .ls_valid_i    (ls_valid_i),
        .ls_we_i       (ls_we_i),
        .ls_addr_i     (ls_addr_i),
        .ls_wdata_i    (ls_wdata_i),
        .ls_strb_i     (ls_strb_i),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_strb_o    (mem_strb_o),
        .issue_fetch_o (issue_fetch),
        .issue_load_o  (issue_load)
    );

    // Pack the read tags in capture-entry order.
    always_comb begin
        issue_vec            = '0;
        issue_vec[CAP_INSTR] = issue_fetch;
        issue_vec[CAP_LOAD]  = issue_load;
    end

    tps_rd_capture #(
        .DATA_W (DATA_W),
        .NCAP   (NCAP)
    ) u_cap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .issue_i (issue_vec),
        .rdata_i (mem_rdata_i),
        .cap_o   (cap)
    );

    assign phase_o     = (phase == PH_ODD);
    assign en_fetch_o  = en_vec[int'(STG_FETCH)];
    assign en_decode_o = en_vec[int'(STG_DECODE)];
    assign en_exec_o   = en_vec[int'(STG_EXEC)];
    assign en_memwb_o  = en_vec[int'(STG_MEMWB)];
    assign instr_o     = cap[CAP_INSTR];
    assign load_data_o = cap[CAP_LOAD];

endmodule

// File: rtl/twophase_seq_chk.sv
// Checker for twophase_seq, attached by bind. Observes ports only.
module twophase_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int STRB_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              stall_i,
    input logic              phase_o,
    input logic              en_fetch_o,
    input logic              en_decode_o,
    input logic              en_exec_o,
    input logic              en_memwb_o,
    input logic [ADDR_W-1:0] ls_addr_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [STRB_W-1:0] mem_strb_o
);

    AST_NO_FETCH_WITH_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(en_fetch_o && en_memwb_o)); // R4

    AST_PHASE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(stall_i)) |-> (phase_o != $past(phase_o))); // R2

    AST_STALL_HOLDS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(stall_i)) |-> $stable(phase_o)); // R9

    AST_STALL_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |-> !(en_fetch_o || en_decode_o || en_exec_o || en_memwb_o)); // R9

    AST_EVEN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!phase_o && !stall_i) |-> (en_fetch_o && en_exec_o && !en_decode_o)); // R3

    AST_EVEN_NO_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_o |-> (mem_strb_o == '0)); // R6

    AST_ODD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o |-> (mem_addr_o == ls_addr_i)); // R5

endmodule

bind twophase_seq twophase_seq_chk #(
    .ADDR_W (ADDR_W),
    .STRB_W (STRB_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .phase_o     (phase_o),
    .en_fetch_o  (en_fetch_o),
    .en_decode_o (en_decode_o),
    .en_exec_o   (en_exec_o),
    .en_memwb_o  (en_memwb_o),
    .ls_addr_i   (ls_addr_i),
    .mem_addr_o  (mem_addr_o),
    .mem_strb_o  (mem_strb_o)
);

// File: tb/twophase_seq_bench.sv
`timescale 1ns/1ps
module twophase_seq_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stall;
    logic [AW-1:0] pc;
    logic          ls_valid;
    logic          ls_we;
    logic [AW-1:0] ls_addr;
    logic [DW-1:0] ls_wdata;
    logic [SW-1:0] ls_strb;
    logic [DW-1:0] mem_rdata;
    logic          phase;
    logic          en_f, en_d, en_x, en_m;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [SW-1:0] mem_strb;
    logic [DW-1:0] instr;
    logic [DW-1:0] ldata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    twophase_seq #(.ADDR_W(AW), .DATA_W(DW), .STRB_W(SW)) u_twophase_seq (
        .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .pc_i(pc),
        .ls_valid_i(ls_valid), .ls_we_i(ls_we), .ls_addr_i(ls_addr),
        .ls_wdata_i(ls_wdata), .ls_strb_i(ls_strb), .mem_rdata_i(mem_rdata),
        .phase_o(phase), .en_fetch_o(en_f), .en_decode_o(en_d),
        .en_exec_o(en_x), .en_memwb_o(en_m), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_strb_o(mem_strb),
        .instr_o(instr), .load_data_o(ldata)
    );

    // Memory model: contents are a fixed function of the address, one cycle latency.
    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'h0F0F};
    endfunction

    always_ff @(posedge clk) mem_rdata <= mem_fn(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait at falling edges until the phase matches p.
    task automatic align(input logic p);
        @(negedge clk);
        while (phase !== p) @(negedge clk);
    endtask

    task automatic idle_inputs();
        stall = 0; ls_valid = 0; ls_we = 0; ls_addr = '0; ls_wdata = '0; ls_strb = '0;
    endtask

    task automatic t_reset();
        rst_n = 0; idle_inputs(); pc = 32'h40;
        repeat (3) @(negedge clk);
        #1;
        chk(phase == 1'b0, "R1 phase in reset", 64'(phase), 0);
        chk(instr == '0 && ldata == '0, "R1 capture regs", 64'(instr | ldata), 0);
        chk(mem_strb == '0, "R1 strobe", 64'(mem_strb), 0);
        @(negedge clk); rst_n = 1; #1;
        chk(phase == 1'b0 && en_f && en_x && !en_d && !en_m, "R1 first cycle is fetch",
            64'({phase, en_f, en_d, en_x, en_m}), 64'b0_1010);
    endtask

    task automatic t_alternate();
        logic p0;
        align(1'b0);
        p0 = phase;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            chk(phase == (p0 ^ i[0]), "R2 phase toggles", 64'(phase), 64'(p0 ^ i[0]));
            if (!phase)
                chk(en_f && en_x && !en_d && !en_m, "R3 even pair",
                    64'({en_f, en_d, en_x, en_m}), 64'b1010);
            else
                chk(!en_f && !en_x && en_d && en_m, "R4 odd pair",
                    64'({en_f, en_d, en_x, en_m}), 64'b0101);
            chk(!(en_f && en_m), "R4 fetch and mem exclusive", 64'({en_f, en_m}), 0);
        end
    endtask

    task automatic t_route();
        align(1'b0);
        for (int i = 0; i < 6; i++) begin
            if (i > 0) @(negedge clk);
            pc = 32'h100 + 4 * i; ls_valid = 1; ls_we = 0; ls_addr = 32'h8000 + 8 * i;
            #1;
            if (i % 2 == 0)
                chk(mem_addr == pc, "R5 even address is pc", 64'(mem_addr), 64'(pc));
            else
                chk(mem_addr == ls_addr, "R5 odd address is ls", 64'(mem_addr), 64'(ls_addr));
        end
        idle_inputs();
    endtask

    task automatic t_write();
        logic [DW-1:0] ld_before;
        align(1'b0);
        ls_valid = 1; ls_we = 1; ls_addr = 32'h9000; ls_wdata = 32'hCAFE_F00D; ls_strb = 4'b0110;
        #1;
        chk(mem_strb == '0 && mem_wdata == '0, "R6 no write in even", 64'(mem_strb), 0);
        @(negedge clk); #1;
        chk(mem_strb == 4'b0110, "R6 strobe in odd", 64'(mem_strb), 64'h6);
        chk(mem_wdata == 32'hCAFE_F00D, "R6 data in odd", 64'(mem_wdata), 64'hCAFEF00D);
        ld_before = ldata;
        @(negedge clk); ls_valid = 0;
        @(negedge clk); #1;
        chk(phase == 1'b1 && mem_strb == '0, "R6 idle odd no strobe", 64'(mem_strb), 0);
        @(negedge clk); #1;
        chk(ldata == ld_before, "R8 store leaves load data", 64'(ldata), 64'(ld_before));
        idle_inputs();
    endtask

    task automatic t_stall();
        align(1'b1);
        ls_valid = 1; ls_we = 1; ls_strb = 4'hF; ls_addr = 32'hA000;
        stall = 1;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            chk(!(en_f || en_d || en_x || en_m), "R9 enables low",
                64'({en_f, en_d, en_x, en_m}), 0);
            chk(phase == 1'b1, "R9 phase held", 64'(phase), 1);
            chk(mem_strb == '0, "R9 strobe low", 64'(mem_strb), 0);
        end
        @(negedge clk); stall = 0; #1;
        chk(phase == 1'b1 && en_d && en_m && !en_f, "R10 resumes in odd",
            64'({phase, en_f, en_d, en_x, en_m}), 64'b1_0101);
        chk(mem_strb == 4'hF, "R10 store proceeds", 64'(mem_strb), 64'hF);
        @(negedge clk); #1;
        chk(phase == 1'b0 && en_f, "R10 then even", 64'(phase), 0);
        idle_inputs();
    endtask

    task automatic t_fetch_capture();
        align(1'b0);
        pc = 32'h0000_1234;
        @(negedge clk); ls_valid = 1; ls_we = 0; ls_addr = 32'h0000_7777;
        @(negedge clk); ls_valid = 0; #1;
        chk(instr == mem_fn(32'h1234), "R7 instruction captured",
            64'(instr), 64'(mem_fn(32'h1234)));
    endtask

    task automatic t_load_capture();
        align(1'b1);
        ls_valid = 1; ls_we = 0; ls_addr = 32'h0003_BEEF;
        @(negedge clk); ls_valid = 0;
        @(negedge clk); #1;
        chk(ldata == mem_fn(32'h0003_BEEF), "R8 load captured",
            64'(ldata), 64'(mem_fn(32'h0003_BEEF)));
        @(negedge clk); @(negedge clk); #1;
        chk(ldata == mem_fn(32'h0003_BEEF), "R8 idle odd keeps load data",
            64'(ldata), 64'(mem_fn(32'h0003_BEEF)));
    endtask

    initial begin
        t_reset();
        t_alternate();
        t_route();
        t_write();
        t_stall();
        t_fetch_capture();
        t_load_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule